// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block is the descriptor-walking half of an SD host controller's data path. Software lays out a chain of descriptors in system memory, sets a start pointer, an address-mode bit, the total byte count it expects to move and a two-bit engine select, then pulses `start`. The engine fetches each descriptor one 32-bit word at a time over a single-outstanding read port and decodes it. It then does one of three things: hands a transfer request to an external data mover, jumps to another descriptor, or skips to the next slot.

A descriptor holds a 16-bit attribute, a 16-bit length and an address. The address is 32 bits in the narrow mode, and in the wide mode it has a 32-bit upper word after it. The walk ends after the descriptor whose End bit is set. At that point the engine compares the bytes it has moved against the programmed total. A bad descriptor or a count mismatch stops the engine and raises a sticky error flag. A 3-bit status records the cause and what the engine was doing when it stopped.

Top module: `adma_engine`

## Requirements
- R1: A `start` pulse in the idle state is accepted only when `cfg_dma_sel` equals 2'b10. For any other select value the engine stays idle, issues no read, and leaves `err_irq` and `err_status` unchanged.
- R2: In narrow mode (`cfg_addr64`=0) a descriptor is 8 bytes long. The word at pointer P holds the attribute in bits 15:0 and the length in bits 31:16. The word at P+4 holds the address. Only the low 32 bits of `cfg_desc_ptr` are used, and the upper 32 bits of `rd_addr` and `mv_addr` stay zero.
- R3: In wide mode (`cfg_addr64`=1) a descriptor is 12 bytes long. The word at P+8 holds address bits 63:32, and all 64 bits of `cfg_desc_ptr` are used.
- R4: Attribute bit 0 is Valid, bit 1 is End and bit 2 is Interrupt, and bits 5:4 give the action. Action 2'b10 raises one `mv_req` carrying the descriptor address and the length in bytes, where a length field of 0 means 65536. The request holds until `mv_done`, and the pointer then advances by the descriptor size.
- R5: Action 2'b11 (link) loads the descriptor's address as the next pointer and moves no data.
- R6: Action 2'b00 (and the unused code 2'b01) moves no data and advances the pointer by the descriptor size.
- R7: The chain ends after the action of the descriptor whose End bit is set. On a clean finish, `done` pulses for one cycle in the same cycle that `busy` falls.
- R8: A fetched descriptor with Valid clear stops the engine without moving data. It sets `err_irq` and writes `err_status` = 3'b001.
- R9: At the end of the chain, if the sum of the transfer lengths differs from `cfg_byte_total`, the engine sets `err_irq` and gives no `done` pulse. `err_status` is then 3'b111 when the last action was a transfer, and 3'b101 when it was a link or no-op.
- R10: A valid descriptor with the Interrupt bit set gives exactly one single-cycle `desc_irq` pulse once its action completes.
- R11: `err_irq` and `err_status` hold their values until the next accepted start, which clears both.
- R12: The read port has at most one request in flight, and `rd_addr` holds steady until `rd_valid` is seen. A read request and a move request are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dma_sel | input | 2 | Engine select; 2'b10 enables this engine |
| cfg_addr64 | input | 1 | 1 = wide (12-byte) descriptors, 0 = narrow (8-byte) |
| cfg_desc_ptr | input | 64 | Address of the first descriptor |
| cfg_byte_total | input | TOTAL_W | Expected byte count of the whole chain |
| start | input | 1 | Start pulse |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 64 | Byte address of the requested word |
| rd_valid | input | 1 | Read data valid, completes the request |
| rd_data | input | 32 | Read data word |
| mv_req | output | 1 | Data mover request, held until `mv_done` |
| mv_addr | output | 64 | System address for the move |
| mv_len | output | 17 | Byte count for the move (1..65536) |
| mv_done | input | 1 | Data mover completion |
| busy | output | 1 | Engine is walking a chain |
| done | output | 1 | One-cycle pulse on a clean finish |
| desc_irq | output | 1 | One-cycle pulse for a descriptor with its Interrupt bit set |
| err_irq | output | 1 | Sticky error flag |
| err_status | output | 3 | Bit 2 is a length mismatch; bits 1:0 are 01 (fetch) or 11 (transfer) at the time of the error |

## Verification
The bench goes after the zero-length descriptor first. A design that treats length 0 as 0 bytes would request an empty move and then report a mismatch against a 65536-byte total. The bench then runs link chains in both address modes. An engine that added the descriptor size after a link, or dropped the upper address word, would fetch from the wrong place and produce a different move sequence. Two mismatch cases, one ending on a transfer and one on a no-op, expose a status that records the wrong state. A start with the wrong select, placed right after an error, catches an engine that starts anyway or wipes the error status it should keep. A narrow-mode run with garbage in the upper pointer bits catches a missing mask.

// File: rtl/adma_pkg.sv
// Package adma_pkg
// Shared constants, field positions and helpers for the descriptor DMA
// engine. Assumes 64-bit system addresses and 32-bit descriptor words.
package adma_pkg;

    localparam int ADDR_W      = 64;
    localparam int WORD_W      = 32;
    localparam int HALF_W      = ADDR_W / 2;
    localparam int LEN_W       = 16;
    localparam int MOVE_W      = LEN_W + 1;
    localparam int NARROW_SIZE = 8;
    localparam int WIDE_SIZE   = 12;

    // Attribute bit positions
    localparam int A_VALID = 0;
    localparam int A_END   = 1;
    localparam int A_INT   = 2;
    localparam int A_ACT_LO = 4;

    // Engine select value that enables this engine
    localparam logic [1:0] SEL_DESC = 2'b10;

    typedef enum logic [1:0] {
        ACT_NOP  = 2'b00,
        ACT_RSV  = 2'b01,
        ACT_MOVE = 2'b10,
        ACT_LINK = 2'b11
    } act_e;

    // State codes captured in the error status
    localparam logic [1:0] ES_STOP  = 2'b00;
    localparam logic [1:0] ES_FETCH = 2'b01;
    localparam logic [1:0] ES_MOVE  = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_FETCH = 2'b01,
        ST_MOVE  = 2'b10
    } eng_st_e;

    // Byte count of a length field; zero encodes the maximum
    function automatic logic [MOVE_W-1:0] len_bytes(input logic [LEN_W-1:0] l);
        return (l == '0) ? MOVE_W'(1) << LEN_W : {1'b0, l};
    endfunction

    // Pointer as seen in the selected address mode
    function automatic logic [ADDR_W-1:0] mode_ptr(input logic [ADDR_W-1:0] p,
                                                   input logic wide);
        return wide ? p : {{HALF_W{1'b0}}, p[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/adma_fetch.sv
// Module adma_fetch
// Reads one descriptor as two (narrow) or three (wide) consecutive 32-bit
// words from a single-outstanding read port and presents its decoded fields.
// Assumes go is only pulsed while no fetch is in progress; fields stay
// valid from the done pulse until the next go.
module adma_fetch
    import adma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              wide,
    input  logic [ADDR_W-1:0] base,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              done,
    output logic              f_valid,
    output logic              f_end,
    output logic              f_int,
    output act_e              f_act,
    output logic [LEN_W-1:0]  f_len,
    output logic [ADDR_W-1:0] f_addr
);

    localparam int IDX_W = 2;

    logic             active;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;

    // Index of the final word of a descriptor in the current mode
    assign last_idx = wide ? IDX_W'(2) : IDX_W'(1);

    // Word address: base plus four bytes per word already read
    assign rd_req  = active;
    assign rd_addr = base + ADDR_W'({idx, 2'b00});

    // Word sequencer and field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            idx     <= '0;
            done    <= 1'b0;
            f_valid <= 1'b0;
            f_end   <= 1'b0;
            f_int   <= 1'b0;
            f_act   <= ACT_NOP;
            f_len   <= '0;
            f_addr  <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active <= 1'b1;
                idx    <= '0;
                f_addr <= '0;
            end else if (active && rd_valid) begin
                case (idx)
                    2'd0: begin
                        f_valid <= rd_data[A_VALID];
                        f_end   <= rd_data[A_END];
                        f_int   <= rd_data[A_INT];
                        f_act   <= act_e'(rd_data[A_ACT_LO +: 2]);
                        f_len   <= rd_data[WORD_W-1 -: LEN_W];
                    end
                    2'd1:    f_addr[HALF_W-1:0]      <= rd_data;
                    default: f_addr[ADDR_W-1:HALF_W] <= rd_data;
                endcase
                if (idx == last_idx) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/adma_tally.sv
// Module adma_tally
// Sums the byte counts of all transfer descriptors in a chain and compares
// the sum with the programmed total. One extra accumulator bit keeps a sum
// that overshoots the total from wrapping back to equality.
module adma_tally
    import adma_pkg::*;
#(
    parameter int TOTAL_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               add,
    input  logic [MOVE_W-1:0]  add_bytes,
    input  logic [TOTAL_W-1:0] total,
    output logic               mismatch
);

    localparam int ACC_W = TOTAL_W + 1;

    logic [ACC_W-1:0] acc;

    // Running sum of transferred bytes
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (add)
            acc <= acc + ACC_W'(add_bytes);
    end

    // Disagreement between the sum and the expected total
    assign mismatch = (acc != {1'b0, total});

endmodule

// File: rtl/adma_engine.sv
// Module adma_engine
// Top of the descriptor DMA engine. Accepts a start when selected, walks
// the descriptor chain through adma_fetch, hands transfers to an external
// data mover, follows links, and finishes on the End bit with a byte-count
// check. Errors stop the walk and are held until the next accepted start.
// Assumes the configuration inputs are stable while busy.
module adma_engine
    import adma_pkg::*;
#(
    parameter int TOTAL_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_dma_sel,
    input  logic               cfg_addr64,
    input  logic [ADDR_W-1:0]  cfg_desc_ptr,
    input  logic [TOTAL_W-1:0] cfg_byte_total,
    input  logic               start,
    output logic               rd_req,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_valid,
    input  logic [WORD_W-1:0]  rd_data,
    output logic               mv_req,
    output logic [ADDR_W-1:0]  mv_addr,
    output logic [MOVE_W-1:0]  mv_len,
    input  logic               mv_done,
    output logic               busy,
    output logic               done,
    output logic               desc_irq,
    output logic               err_irq,
    output logic [2:0]         err_status
);

    eng_st_e           st;
    logic [ADDR_W-1:0] ptr;
    logic              mode64_q;
    logic              fetch_go;

    logic              f_done;
    logic              f_valid;
    logic              f_end;
    logic              f_int;
    act_e              f_act;
    logic [LEN_W-1:0]  f_len;
    logic [ADDR_W-1:0] f_addr;

    logic              start_ok;
    logic              advance;
    logic [1:0]        adv_code;
    logic              mismatch;
    logic              tally_add;
    logic [ADDR_W-1:0] desc_size;
    logic [ADDR_W-1:0] ptr_next;

    adma_fetch u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (fetch_go),
        .wide     (mode64_q),
        .base     (ptr),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .done     (f_done),
        .f_valid  (f_valid),
        .f_end    (f_end),
        .f_int    (f_int),
        .f_act    (f_act),
        .f_len    (f_len),
        .f_addr   (f_addr)
    );

    adma_tally #(.TOTAL_W(TOTAL_W)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_ok),
        .add       (tally_add),
        .add_bytes (len_bytes(f_len)),
        .total     (cfg_byte_total),
        .mismatch  (mismatch)
    );

    // Start is taken only when idle and this engine is selected
    assign start_ok  = (st == ST_IDLE) && start && (cfg_dma_sel == SEL_DESC);
    // Count a transfer's bytes as soon as it is decoded
    assign tally_add = (st == ST_FETCH) && f_done && f_valid && (f_act == ACT_MOVE);
    // Stride to the following slot and the pointer it gives
    assign desc_size = mode64_q ? ADDR_W'(WIDE_SIZE) : ADDR_W'(NARROW_SIZE);
    assign ptr_next  = mode_ptr(ptr + desc_size, mode64_q);
    assign busy      = (st != ST_IDLE);

    // Detects a completed descriptor action and the state it completed in
    always_comb begin
        advance  = 1'b0;
        adv_code = ES_FETCH;
        if (st == ST_FETCH && f_done && f_valid && f_act != ACT_MOVE) begin
            advance = 1'b1;
        end else if (st == ST_MOVE && mv_done) begin
            advance  = 1'b1;
            adv_code = ES_MOVE;
        end
    end

    // Engine sequencing, mover request and status capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            ptr        <= '0;
            mode64_q   <= 1'b0;
            fetch_go   <= 1'b0;
            mv_req     <= 1'b0;
            mv_addr    <= '0;
            mv_len     <= '0;
            done       <= 1'b0;
            desc_irq   <= 1'b0;
            err_irq    <= 1'b0;
            err_status <= {1'b0, ES_STOP};
        end else begin
            fetch_go <= 1'b0;
            done     <= 1'b0;
            desc_irq <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_ok) begin
                        mode64_q   <= cfg_addr64;
                        ptr        <= mode_ptr(cfg_desc_ptr, cfg_addr64);
                        fetch_go   <= 1'b1;
                        err_irq    <= 1'b0;
                        err_status <= {1'b0, ES_STOP};
                        st         <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (f_done) begin
                        if (!f_valid) begin
                            err_irq    <= 1'b1;
                            err_status <= {1'b0, ES_FETCH};
                            st         <= ST_IDLE;
                        end else if (f_act == ACT_MOVE) begin
                            mv_req  <= 1'b1;
                            mv_addr <= mode_ptr(f_addr, mode64_q);
                            mv_len  <= len_bytes(f_len);
                            st      <= ST_MOVE;
                        end else if (f_act == ACT_LINK) begin
                            ptr <= mode_ptr(f_addr, mode64_q);
                        end else begin
                            ptr <= ptr_next;
                        end
                    end
                end
                ST_MOVE: begin
                    if (mv_done) begin
                        mv_req <= 1'b0;
                        ptr    <= ptr_next;
                    end
                end
                default: st <= ST_IDLE;
            endcase

            // Finish or continue after a completed action
            if (advance) begin
                desc_irq <= f_int;
                if (f_end) begin
                    st <= ST_IDLE;
                    if (mismatch) begin
                        err_irq    <= 1'b1;
                        err_status <= {1'b1, adv_code};
                    end else begin
                        done <= 1'b1;
                    end
                end else begin
                    fetch_go <= 1'b1;
                    st       <= ST_FETCH;
                end
            end
        end
    end

endmodule

// File: rtl/adma_engine_chk.sv
// Module adma_engine_chk
// Protocol and status properties of adma_engine, attached by bind.
module adma_engine_chk
    import adma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        cfg_dma_sel,
    input logic              busy,
    input logic              done,
    input logic              err_irq,
    input logic              desc_irq,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              mv_req,
    input logic              mv_done,
    input logic [ADDR_W-1:0] mv_addr,
    input logic [MOVE_W-1:0] mv_len,
    input logic              mode64_q
);

    p_sel_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && cfg_dma_sel != SEL_DESC) |=> !busy);

    p_narrow_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !mode64_q) |-> (rd_addr[ADDR_W-1:HALF_W] == '0));

    p_move_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !mv_done) |=> (mv_req && $stable(mv_addr) && $stable(mv_len)));

    p_move_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req |-> (mv_len != '0 && mv_len <= (MOVE_W'(1) << LEN_W)));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !err_irq));

    p_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_irq) |-> (!busy && !mv_req));

    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        desc_irq |=> !desc_irq);

    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !mv_req);

endmodule

bind adma_engine adma_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cfg_dma_sel (cfg_dma_sel),
    .busy        (busy),
    .done        (done),
    .err_irq     (err_irq),
    .desc_irq    (desc_irq),
    .rd_req      (rd_req),
    .rd_valid    (rd_valid),
    .rd_addr     (rd_addr),
    .mv_req      (mv_req),
    .mv_done     (mv_done),
    .mv_addr     (mv_addr),
    .mv_len      (mv_len),
    .mode64_q    (mode64_q)
);

// File: tb/adma_engine_tb_top.sv
// Bench for adma_engine: a behavioural chain walker predicts the move
// sequence and final status; memory and mover responders run every clock.
module adma_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_dma_sel = 2'b10;
    logic        cfg_addr64 = 1'b0;
    logic [63:0] cfg_desc_ptr = '0;
    logic [31:0] cfg_byte_total = '0;
    logic        start = 1'b0;
    logic        rd_req;
    logic [63:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        mv_req;
    logic [63:0] mv_addr;
    logic [16:0] mv_len;
    logic        mv_done = 1'b0;
    logic        busy, done, desc_irq, err_irq;
    logic [2:0]  err_status;

    always #10 clk = ~clk;

    adma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_dma_sel(cfg_dma_sel), .cfg_addr64(cfg_addr64),
        .cfg_desc_ptr(cfg_desc_ptr), .cfg_byte_total(cfg_byte_total), .start(start),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_done(mv_done),
        .busy(busy), .done(done), .desc_irq(desc_irq), .err_irq(err_irq),
        .err_status(err_status)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit [31:0] mem [bit [63:0]];

    logic [63:0] exp_addr_q[$];
    int          exp_len_q[$];
    int          mv_seen, rd_seen, done_seen, irq_seen, mv_wait;
    int          exp_err, exp_done, exp_irq;
    logic [2:0]  exp_status;
    string       cur_req = "R4";

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit [31:0] rd_mem(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Places one descriptor; attribute bits: 0 valid, 1 end, 2 int, 5:4 action
    task automatic put_desc(input logic [63:0] p, input bit wide, input logic [15:0] attr,
                            input logic [15:0] len, input logic [63:0] a);
        mem[p]     = {len, attr};
        mem[p + 4] = a[31:0];
        if (wide) mem[p + 8] = a[63:32];
    endtask

    // Behavioural walk of the chain from the requirements
    task automatic model(input logic [63:0] p0, input bit wide, input int total);
        logic [63:0] p;
        longint sum;
        logic [1:0] last;
        exp_addr_q.delete(); exp_len_q.delete();
        exp_err = 0; exp_done = 0; exp_irq = 0; exp_status = 3'b000;
        p = wide ? p0 : {32'h0, p0[31:0]};
        sum = 0;
        for (int k = 0; k < 64; k++) begin
            logic [31:0] w0;
            logic [63:0] a;
            int bytes;
            w0 = rd_mem(p);
            a = {wide ? rd_mem(p + 8) : 32'h0, rd_mem(p + 4)};
            if (!w0[0]) begin exp_err = 1; exp_status = 3'b001; break; end
            if (w0[5:4] == 2'b10) begin
                bytes = (w0[31:16] == 0) ? 65536 : int'(w0[31:16]);
                exp_addr_q.push_back(a); exp_len_q.push_back(bytes);
                sum += bytes; last = 2'b11;
                p = p + (wide ? 12 : 8);
            end else if (w0[5:4] == 2'b11) begin
                p = a; last = 2'b01;
            end else begin
                p = p + (wide ? 12 : 8); last = 2'b01;
            end
            if (!wide) p[63:32] = 32'h0;
            if (w0[2]) exp_irq++;
            if (w0[1]) begin
                if (sum != longint'(total)) begin exp_err = 1; exp_status = {1'b1, last}; end
                else exp_done = 1;
                break;
            end
        end
    endtask

    // Memory and mover responders with per-clock comparison of move requests
    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid) rd_valid = 1'b0;
            else if (rd_req) begin
                rd_data  = rd_mem(rd_addr);
                rd_valid = 1'b1;
                rd_seen++;
            end
            if (mv_done) begin
                mv_done = 1'b0;
                mv_wait = 0;
            end else if (mv_req) begin
                mv_wait++;
                if (mv_wait == 3) begin
                    mv_done = 1'b1;
                    if (exp_addr_q.size() == 0) begin
                        chk(1'b0, cur_req, "unexpected move addr", mv_addr, 0);
                    end else begin
                        logic [63:0] ea;
                        int el;
                        ea = exp_addr_q.pop_front();
                        el = exp_len_q.pop_front();
                        chk(mv_addr == ea, cur_req, "move addr", mv_addr, ea);
                        chk(int'(mv_len) == el, cur_req, "move len", mv_len, el);
                    end
                    mv_seen++;
                end
            end
            if (done) done_seen++;
            if (desc_irq) irq_seen++;
        end
    end

    task automatic run(input string req, input bit wide, input logic [63:0] p,
                       input int total);
        int guard;
        cur_req = req;
        model(p, wide, total);
        mv_seen = 0; rd_seen = 0; done_seen = 0; irq_seen = 0; mv_wait = 0;
        @(negedge clk);
        cfg_addr64 = wide; cfg_desc_ptr = p; cfg_byte_total = total; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (busy && guard < 20000) begin @(negedge clk); guard++; end
        repeat (2) @(negedge clk);
        chk(!busy, req, "busy after run", busy, 0);
        chk(exp_addr_q.size() == 0, req, "moves missing", exp_addr_q.size(), 0);
        chk(err_irq == exp_err[0], req, "err_irq", err_irq, exp_err);
        chk(err_status == exp_status, req, "err_status", err_status, exp_status);
        chk(done_seen == exp_done, req, "done pulses", done_seen, exp_done);
        chk(irq_seen == exp_irq, req, "desc_irq pulses", irq_seen, exp_irq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(!busy, "R7", "reset busy", busy, 0);
        chk(!rd_req, "R12", "reset rd_req", rd_req, 0);
        chk(!mv_req, "R4", "reset mv_req", mv_req, 0);
        chk(!err_irq, "R11", "reset err_irq", err_irq, 0);
        chk(err_status == 3'b000, "R11", "reset err_status", err_status, 0);

        // R2 narrow chain, upper pointer bits ignored; R10 int on last
        put_desc(64'h1000, 0, 16'h0021, 16'h0200, 64'h2000);
        put_desc(64'h1008, 0, 16'h0021, 16'h0100, 64'h3000);
        put_desc(64'h1010, 0, 16'h0027, 16'h0040, 64'h4000);
        put_desc(64'h1018, 0, 16'h0000, 16'h0000, 64'h0);
        run("R2", 0, 64'hDEAD_0000_0000_1000, 32'h340);

        // R4 zero length means 65536
        put_desc(64'h1100, 0, 16'h0023, 16'h0000, 64'h8000);
        run("R4", 0, 64'h1100, 65536);

        // R5 link and R6 no-op with interrupt
        put_desc(64'h1200, 0, 16'h0005, 16'h1234, 64'hFFFF);
        put_desc(64'h1208, 0, 16'h0021, 16'h0080, 64'h5000);
        put_desc(64'h1210, 0, 16'h0031, 16'h0000, 64'h1400);
        put_desc(64'h1400, 0, 16'h0023, 16'h0020, 64'h6000);
        run("R5", 0, 64'h1200, 32'hA0);

        // R8 invalid descriptor after one transfer
        put_desc(64'h1500, 0, 16'h0021, 16'h0010, 64'h7000);
        put_desc(64'h1508, 0, 16'h0020, 16'h0005, 64'h7100);
        run("R8", 0, 64'h1500, 32'h10);

        // R9 mismatch ending on a transfer
        put_desc(64'h1600, 0, 16'h0023, 16'h0030, 64'h9000);
        run("R9", 0, 64'h1600, 32'h40);

        // R9 mismatch ending on a no-op (R6)
        put_desc(64'h1680, 0, 16'h0021, 16'h0010, 64'hA000);
        put_desc(64'h1688, 0, 16'h0003, 16'h0000, 64'h0);
        run("R9", 0, 64'h1680, 32'h20);

        // R1 wrong select: ignored, status of previous error kept
        cfg_dma_sel = 2'b00;
        rd_seen = 0;
        @(negedge clk);
        cfg_desc_ptr = 64'h1000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk(!busy, "R1", "busy with wrong select", busy, 0);
        chk(rd_seen == 0, "R1", "reads with wrong select", rd_seen, 0);
        chk(err_status == 3'b101, "R1", "status kept", err_status, 3'b101);
        chk(err_irq, "R1", "err_irq kept", err_irq, 1);
        cfg_dma_sel = 2'b10;

        // R3 wide descriptors, upper address words and link; R11 clears error
        put_desc(64'h1_0000_2000, 1, 16'h0021, 16'h0100, 64'h5_1234_0000);
        put_desc(64'h1_0000_200C, 1, 16'h0031, 16'h0000, 64'h1_0000_3000);
        put_desc(64'h1_0000_3000, 1, 16'h0027, 16'h0008, 64'h6_0000_0040);
        run("R3", 1, 64'h1_0000_2000, 32'h108);
        chk(!err_irq, "R11", "error cleared by start", err_irq, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule